// File: doc/BRIEF.md
# Oversample Tick Generator with Divider and Phase-Accumulator Modes

This block turns the system clock into a one-cycle oversample strobe for a serial transmitter and receiver, which expect sixteen strobes per bit. Software-side logic programs a rate value and a mode bit through a simple write strobe. In divider mode the strobe fires once every N clocks, so the bit rate is clk / (16 × N). In phase-accumulator mode the rate value is a fractional increment: each clock adds it to a 16-bit accumulator, and the carry out is the strobe, so the strobe rate is value × clk / 2^16. Divider mode suits slow bit rates. The accumulator mode is meant for 19200 baud and faster, up to the clk / 16 limit.

A run input gates the generator. When run is low, no strobe is produced, and both the counter and the accumulator are held at zero. The first strobe after a restart is therefore always at the same place. A new rate or mode written while the generator runs is held as pending. It becomes active only at the next wrap of the engine in use (counter reload or accumulator carry), so a period is never cut short or stretched in the middle. A write made while stopped takes effect at once.

Top module: `oversample_tick_gen`

## Requirements
- R1: While the active-low reset rstN is asserted, tick is 0 and both rate engines are cleared.
- R2: In divider mode (mode bit 0) with active value N ≥ 2, counting rising edges from the first one that samples runEn high as edge 1, tick is high after edge k exactly when k is a multiple of N.
- R3: In divider mode with active value 0 or 1, tick is high after every edge that samples runEn high.
- R4: In accumulator mode (mode bit 1) with value V, tick is high after edge k exactly when floor(k·V / 2^16) differs from floor((k−1)·V / 2^16).
- R5: An edge that samples runEn low leaves tick low after it. A restart replays the same strobe sequence as a fresh start.
- R6: tick is one cycle wide. In divider mode with N ≥ 2, it is never high after two consecutive edges.
- R7: A rate written while running is applied only at the next wrap of the running engine. The period in progress completes with the old value.
- R8: A mode change written while running is also applied at the next wrap. The newly selected engine starts from zero.
- R9: A write made while runEn is low is active from the first edge after runEn rises.
- R10: In accumulator mode a value of 0 never produces a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Generator enable; low stops and clears the engines |
| cfgWrEn | input | 1 | One-cycle write strobe for the pending configuration |
| cfgWrMode | input | 1 | Mode written with cfgWrEn: 0 divider, 1 phase accumulator |
| cfgWrRate | input | RATE_W (16) | Rate value written with cfgWrEn |
| tick | output | 1 | One-cycle oversample strobe |

## Verification
On every cycle, the assertions check four things. The strobe is silent after a stopped edge and after reset. In divider mode, strobes are never adjacent when the value is two or more, and a divider value of 0 or 1 fires on every cycle. A zero accumulator increment never fires. The active configuration cannot change except at a wrap or while stopped. Only the bench's scenarios can show the exact strobe positions: the divider sweep, the accumulator carry sequence against its arithmetic, the old period running to completion after a mid-run write, and the hand-over between modes.

// File: rtl/tick_gen_pkg.sv
package tick_gen_pkg;
  // mode bit encoding
  localparam logic MODE_DIV = 1'b0;
  localparam logic MODE_NCO = 1'b1;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;  // hold both engines at zero
    logic step;   // advance the selected engine this cycle
  } tick_ctrl_t;
endpackage

// File: rtl/tick_gen_ctrl.sv
module tick_gen_ctrl
  import tick_gen_pkg::*;
#(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              cfgWrEn,
  input  logic              cfgWrMode,
  input  logic [RATE_W-1:0] cfgWrRate,
  input  logic              wrapEvt,
  output tick_ctrl_t        ctrl,
  output logic              actMode,
  output logic [RATE_W-1:0] actRate
);
  logic              pendMode;
  logic [RATE_W-1:0] pendRate;
  logic              nextPendMode;
  logic [RATE_W-1:0] nextPendRate;
  logic              loadAct;

  // a write in the same cycle as a reload is taken at once
  always_comb begin
    nextPendMode = cfgWrEn ? cfgWrMode : pendMode;
    nextPendRate = cfgWrEn ? cfgWrRate : pendRate;
    loadAct      = !runEn || wrapEvt;
    ctrl.clear   = !runEn;
    ctrl.step    = runEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendMode <= MODE_DIV;
      pendRate <= '0;
      actMode  <= MODE_DIV;
      actRate  <= '0;
    end else begin
      pendMode <= nextPendMode;
      pendRate <= nextPendRate;
      if (loadAct) begin
        actMode <= nextPendMode;
        actRate <= nextPendRate;
      end
    end
  end
endmodule

// File: rtl/tick_gen_dp.sv
module tick_gen_dp
  import tick_gen_pkg::*;
#(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tick_ctrl_t        ctrl,
  input  logic              actMode,
  input  logic [RATE_W-1:0] actRate,
  output logic              wrapEvt,
  output logic              tick
);
  localparam logic [RATE_W-1:0] ONE = RATE_W'(1);

  logic [RATE_W-1:0] divCnt;
  logic [RATE_W-1:0] divTerm;
  logic              divHit;
  logic [RATE_W-1:0] phaseAcc;
  logic [RATE_W:0]   phaseSum;
  logic              ncoHit;

  always_comb begin
    divTerm  = (actRate <= ONE) ? '0 : actRate - ONE;
    divHit   = divCnt >= divTerm;
    phaseSum = {1'b0, phaseAcc} + {1'b0, actRate};
    ncoHit   = phaseSum[RATE_W];
    wrapEvt  = ctrl.step && ((actMode == MODE_NCO) ? ncoHit : divHit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt   <= '0;
      phaseAcc <= '0;
      tick     <= 1'b0;
    end else if (ctrl.clear) begin
      divCnt   <= '0;
      phaseAcc <= '0;
      tick     <= 1'b0;
    end else if (ctrl.step) begin
      if (actMode == MODE_NCO) begin
        divCnt   <= '0;
        phaseAcc <= phaseSum[RATE_W-1:0];
        tick     <= ncoHit;
      end else begin
        phaseAcc <= '0;
        divCnt   <= divHit ? '0 : divCnt + ONE;
        tick     <= divHit;
      end
    end else begin
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/oversample_tick_gen.sv
module oversample_tick_gen
  import tick_gen_pkg::*;
#(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              cfgWrEn,
  input  logic              cfgWrMode,
  input  logic [RATE_W-1:0] cfgWrRate,
  output logic              tick
);
  tick_ctrl_t        ctrl;
  logic              actMode;
  logic [RATE_W-1:0] actRate;
  logic              wrapEvt;

  tick_gen_ctrl #(.RATE_W(RATE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn),
    .cfgWrEn(cfgWrEn), .cfgWrMode(cfgWrMode), .cfgWrRate(cfgWrRate),
    .wrapEvt(wrapEvt), .ctrl(ctrl), .actMode(actMode), .actRate(actRate)
  );

  tick_gen_dp #(.RATE_W(RATE_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .actMode(actMode),
    .actRate(actRate), .wrapEvt(wrapEvt), .tick(tick)
  );
endmodule

// File: rtl/oversample_tick_gen_chk.sv
module oversample_tick_gen_chk #(
  parameter int RATE_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              runEn,
  input logic              tick,
  input logic              actMode,
  input logic [RATE_W-1:0] actRate,
  input logic              wrapEvt
);
  // R1: reset leaves the strobe low
  p_reset_quiet_r1: assert property (@(posedge clk) !rstN |=> !tick);

  // R5: a stopped edge produces no strobe
  p_stop_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> !tick);

  // R6: no adjacent strobes in divider mode with value >= 2
  p_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    (tick && runEn && !actMode && actRate >= RATE_W'(2)) |=> !tick);

  // R3: divider value 0 or 1 fires every running cycle
  p_every_cycle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !actMode && actRate <= RATE_W'(1)) |=> tick);

  // R10: zero increment never fires
  p_zero_inc_r10: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && actMode && actRate == '0) |=> !tick);

  // R7: active configuration changes only at a wrap while running
  p_hold_cfg_r7: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !wrapEvt) |=> ($stable(actRate) && $stable(actMode)));
endmodule

bind oversample_tick_gen oversample_tick_gen_chk #(.RATE_W(RATE_W)) u_chk (.*);

// File: tb/oversample_tick_gen_test.sv
module oversample_tick_gen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgWrMode = 1'b0;
  logic [15:0] cfgWrRate = '0;
  logic        tick;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  oversample_tick_gen #(.RATE_W(16)) uut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tickEdge();
    @(posedge clk); #1;
  endtask

  task automatic writeCfg(input logic m, input logic [15:0] v);
    cfgWrEn = 1'b1; cfgWrMode = m; cfgWrRate = v;
    tickEdge();
    cfgWrEn = 1'b0;
  endtask

  function automatic bit expTick(input logic m, input int v, input int k);
    longint a, b;
    int lim;
    if (m) begin
      a = (longint'(k) * v) >> 16;
      b = (longint'(k - 1) * v) >> 16;
      return a != b;
    end
    lim = (v <= 1) ? 1 : v;
    return (k % lim) == 0;
  endfunction

  // stop, write while stopped (R9), start, compare cycles 1..n
  task automatic runCase(input logic m, input int v, input int n, input string req);
    int badK = -1;
    int badA = 0;
    runEn = 1'b0;
    tickEdge();
    writeCfg(m, 16'(v));
    tickEdge();
    runEn = 1'b1;
    for (int k = 1; k <= n; k++) begin
      tickEdge();
      if (tick !== expTick(m, v, k) && badK < 0) begin
        badK = k; badA = int'(tick);
      end
    end
    check(badK < 0, req, badA, badK < 0 ? 0 : int'(expTick(m, v, badK)));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int seen;
    repeat (3) tickEdge();
    check(tick === 1'b0, "R1 reset", int'(tick), 0);
    rstN = 1'b1;
    tickEdge();
    check(tick === 1'b0, "R1 after reset", int'(tick), 0);

    // divider sweep: R2 R3 R6 R9
    for (int v = 0; v <= 20; v++)
      runCase(1'b0, v, 70, (v <= 1) ? "R3 divider every cycle" : "R2 R6 R9 divider period");

    // accumulator: R4 R10
    runCase(1'b1, 16'h8000, 200, "R4 accumulator half");
    runCase(1'b1, 16'hFFFF, 300, "R4 accumulator max");
    runCase(1'b1, 16'h1000, 200, "R4 accumulator 1/16");
    runCase(1'b1, 16'h1235, 400, "R4 accumulator odd");
    runCase(1'b1, 16'h0001, 300, "R4 accumulator tiny");
    runCase(1'b1, 16'h0000, 200, "R10 zero increment");

    // R5: stop mid-run, strobe stays low
    runCase(1'b0, 1, 5, "R3 before stop");
    runEn = 1'b0;
    seen = 0;
    for (int k = 0; k < 12; k++) begin
      tickEdge();
      if (tick) seen++;
    end
    check(seen == 0, "R5 stop silences", seen, 0);
    // R5 restart replays same sequence
    runCase(1'b0, 7, 50, "R5 restart replay");
    runCase(1'b0, 7, 50, "R5 restart replay again");

    // R7: N=5 running, write N=3 before edge 8; ticks 5,10,13,16,19
    runEn = 1'b0; tickEdge();
    writeCfg(1'b0, 16'd5);
    tickEdge();
    runEn = 1'b1;
    seen = 0;
    for (int k = 1; k <= 20; k++) begin
      bit e;
      if (k == 8) begin cfgWrEn = 1'b1; cfgWrMode = 1'b0; cfgWrRate = 16'd3; end
      tickEdge();
      cfgWrEn = 1'b0;
      e = (k == 5) || (k == 10) || (k == 13) || (k == 16) || (k == 19);
      if (tick !== e) seen++;
    end
    check(seen == 0, "R7 mid-run rate write", seen, 0);

    // R8: divider N=4, write accumulator 0x8000 at edge 2; ticks 4,6,8,...
    runEn = 1'b0; tickEdge();
    writeCfg(1'b0, 16'd4);
    tickEdge();
    runEn = 1'b1;
    seen = 0;
    for (int k = 1; k <= 30; k++) begin
      bit e;
      if (k == 2) begin cfgWrEn = 1'b1; cfgWrMode = 1'b1; cfgWrRate = 16'h8000; end
      tickEdge();
      cfgWrEn = 1'b0;
      e = (k == 4) || (k > 4 && ((k - 4) % 2 == 0));
      if (tick !== e) seen++;
    end
    check(seen == 0, "R8 mode hand-over", seen, 0);

    runEn = 1'b0;
    tickEdge();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule